// File: doc/BRIEF.md
# Single-Line Non-Maskable Interrupt Controller

This block watches one external non-maskable interrupt pin and turns activity on it into one interrupt request for the parent interrupt controller. The pin is asynchronous. It is resynchronised first. A programmable trigger type then decides which pin activity counts as an event: a low level, a high level, a falling edge or a rising edge.

Each event sets a sticky pending flag. Software clears the flag by writing a one. An enable bit gates the pending flag onto the registered request output.

Software reaches the block through a plain 32-bit register port. Writes are single-cycle strobes, and read data follows the address combinationally. There are three registers. The trigger register always sits at offset 0x00. A build-time parameter swaps the offsets of the pending register and the enable register, so the block can match either of two address layouts.

Top module: `nmi_line_ctrl`

## Requirements
- R1: The trigger register (offset 0x00) uses bits [1:0] as the trigger type: 0 = active-low level, 1 = falling edge, 2 = active-high level, 3 = rising edge. All 32 bits read back exactly what was last written.
- R2: In the two level modes, the pending flag is set on every clock cycle in which the synchronised pin is at the active level.
- R3: In the two edge modes, each transition of the synchronised pin in the selected direction sets the pending flag once. A transition in the other direction, or a steady pin, sets nothing.
- R4: Writing a value with bit 0 = 1 to the pending register clears the flag. Writing bit 0 = 0 leaves the flag unchanged. In a level mode the clear takes effect only once the active level has gone.
- R5: When an event and a clearing write fall in the same cycle, the pending flag stays set.
- R6: The `irq_out` output is a registered copy of (pending AND enable). The pending flag still latches events while enable is 0.
- R7: Reset (synchronous, active low) sets the trigger register, the pending flag, the enable bit and `irq_out` to 0. The synchroniser resets to the idle-high pin value, so a high pin raises no event after reset.
- R8: With `SWAP_LAYOUT` = 0, pending is at 0x04 and enable is at 0x08. With `SWAP_LAYOUT` = 1, enable is at 0x04 and pending is at 0x08.
- R9: Offsets other than the three mapped ones read as 0, and writes to them change nothing. Reads of the pending and enable registers return 0 in bits [31:1].
- R10: A pin change reaches the pending flag on the third rising clock edge after it and reaches `irq_out` on the fourth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| bus_addr | input | ADDR_W (4) | Byte offset of the register access |
| bus_wr_en | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
Each result has a fixed due time after its stimulus:
- A register write is visible on `bus_rdata` one edge after the strobe.
- A pin change sets the pending flag three edges later.
- `irq_out` follows the pending flag or the enable bit one edge after either changes.

The table-driven part waits five edges after each stimulus before it samples, which covers every one of these due times. The latency test instead reads the pending register after every single edge, to confirm the exact cycle. Same-cycle races are steered from falling clock edges: the clearing write is placed in the cycle where a detected edge is due, or in the cycle where a level is still visible.

// File: rtl/nmi_line_pkg.sv
// Package: shared trigger encoding and layout helpers for the single-line
// interrupt controller. Assumes byte-addressed 32-bit register slots.
package nmi_line_pkg;

    // Trigger type held in bits [1:0] of the trigger register.
    typedef enum logic [1:0] {
        TRIG_LVL_LO = 2'd0,
        TRIG_FALL   = 2'd1,
        TRIG_LVL_HI = 2'd2,
        TRIG_RISE   = 2'd3
    } trig_e;

    // Byte offsets of the two slots that follow the trigger register.
    localparam int unsigned SLOT_A = 4;
    localparam int unsigned SLOT_B = 8;

    // True when the trigger type reacts to a level rather than an edge.
    function automatic logic is_level(input trig_e t);
        return (t == TRIG_LVL_LO) || (t == TRIG_LVL_HI);
    endfunction

endpackage

// File: rtl/nmi_line_sync.sv
// Module: multi-stage synchroniser for the asynchronous interrupt pin.
// Assumes STAGES >= 2. Every flop resets to RST_VAL (the idle pin level), so
// that leaving reset does not itself look like pin activity.
module nmi_line_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw pin in the first stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= RST_VAL;
                    else        chain_q[0] <= pin_i;
                end
            end else begin : g_next
                // Pass the sample one stage down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= RST_VAL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/nmi_line_detect.sv
// Module: turns the synchronised pin into a one-cycle event strobe (edge
// modes) or a per-cycle active strobe (level modes). It assumes that sync_i
// is already in the clk domain. The previous sample resets to RST_VAL.
module nmi_line_detect
    import nmi_line_pkg::*;
#(
    parameter logic RST_VAL = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sync_i,
    input  trig_e trig_i,
    output logic  hit_o
);

    logic prev_q;
    logic rise_w;
    logic fall_w;

    // Hold the previous synchronised sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= sync_i;
    end

    assign rise_w = sync_i & ~prev_q;
    assign fall_w = ~sync_i & prev_q;

    // Pick the event condition selected by the trigger type.
    always_comb begin
        unique case (trig_i)
            TRIG_LVL_LO: hit_o = ~sync_i;
            TRIG_FALL:   hit_o = fall_w;
            TRIG_LVL_HI: hit_o = sync_i;
            TRIG_RISE:   hit_o = rise_w;
            default:     hit_o = 1'b0;
        endcase
    end

    // An edge event never repeats in the next cycle while the mode holds.
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && !is_level(trig_i)) |=> (!hit_o || trig_i != $past(trig_i))); // R3

endmodule

// File: rtl/nmi_line_regs.sv
// Module: register file and request logic. It decodes the byte offset, holds
// the trigger register, the sticky pending flag and the enable bit, and
// registers the gated request. It assumes one write strobe per access and
// ADDR_W >= 4.
module nmi_line_regs
    import nmi_line_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter bit          SWAP_LAYOUT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_wr_en_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              set_i,
    output trig_e             trig_o,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] OFF_CTRL = '0;
    localparam logic [ADDR_W-1:0] OFF_PEND = SWAP_LAYOUT ? ADDR_W'(SLOT_B) : ADDR_W'(SLOT_A);
    localparam logic [ADDR_W-1:0] OFF_EN   = SWAP_LAYOUT ? ADDR_W'(SLOT_A) : ADDR_W'(SLOT_B);

    logic [DATA_W-1:0] ctrl_q;
    logic              pend_q;
    logic              en_q;
    logic              irq_q;
    logic              sel_ctrl;
    logic              sel_pend;
    logic              sel_en;
    logic              clr_w;

    assign sel_ctrl = (bus_addr_i == OFF_CTRL);
    assign sel_pend = (bus_addr_i == OFF_PEND);
    assign sel_en   = (bus_addr_i == OFF_EN);
    assign clr_w    = bus_wr_en_i && sel_pend && bus_wdata_i[0];

    // Store every written bit of the trigger register.
    always_ff @(posedge clk) begin
        if (!rst_n)                        ctrl_q <= '0;
        else if (bus_wr_en_i && sel_ctrl)  ctrl_q <= bus_wdata_i;
    end

    // Sticky pending flag: a detected event overrides a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (set_i)  pend_q <= 1'b1;
        else if (clr_w)  pend_q <= 1'b0;
    end

    // Enable bit follows bit 0 of each enable write.
    always_ff @(posedge clk) begin
        if (!rst_n)                     en_q <= 1'b0;
        else if (bus_wr_en_i && sel_en) en_q <= bus_wdata_i[0];
    end

    // Register the gated request towards the parent controller.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= pend_q & en_q;
    end

    // Return the addressed register, zero-extended, or zero if unmapped.
    always_comb begin
        bus_rdata_o = '0;
        if (sel_ctrl)      bus_rdata_o = ctrl_q;
        else if (sel_pend) bus_rdata_o[0] = pend_q;
        else if (sel_en)   bus_rdata_o[0] = en_q;
    end

    assign trig_o = trig_e'(ctrl_q[1:0]);
    assign irq_o  = irq_q;

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_w && !set_i) |=> !pend_q); // R4

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_q); // R5

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(pend_q && en_q)); // R6

    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!en_q && !pend_q && !irq_q && ctrl_q == '0)); // R7

    AST_UNMAPPED_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en_i && !sel_ctrl && !sel_pend && !sel_en) |=> ($stable(ctrl_q) && $stable(en_q))); // R9

endmodule

// File: rtl/nmi_line_ctrl.sv
// Module: top of the single-line interrupt controller. It chains the pin
// synchroniser, the trigger detector and the register file. It assumes that
// the pin idles high, which is the value the synchroniser resets to.
module nmi_line_ctrl
    import nmi_line_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2,
    parameter bit          SWAP_LAYOUT = 1'b0,
    parameter logic        PIN_IDLE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_pin,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr_en,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic  pin_sync;
    logic  hit;
    trig_e trig;

    nmi_line_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (nmi_pin),
        .sync_o (pin_sync)
    );

    nmi_line_detect #(
        .RST_VAL (PIN_IDLE)
    ) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (pin_sync),
        .trig_i (trig),
        .hit_o  (hit)
    );

    nmi_line_regs #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SWAP_LAYOUT (SWAP_LAYOUT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (bus_addr),
        .bus_wr_en_i (bus_wr_en),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .set_i       (hit),
        .trig_o      (trig),
        .irq_o       (irq_out)
    );

endmodule

// File: tb/nmi_line_ctrl_bench.sv
module nmi_line_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_pin = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [31:0] swp_rdata;
    logic        swp_irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    nmi_line_ctrl u_nmi_line_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    nmi_line_ctrl #(.SWAP_LAYOUT(1'b1)) u_nmi_line_ctrl_swap (
        .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .bus_addr(bus_addr),
        .bus_wr_en(bus_wr_en), .bus_wdata(bus_wdata), .bus_rdata(swp_rdata), .irq_out(swp_irq)
    );

    // Watchdog: an overlong run counts as one failed check.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected at most 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual 0x%08h, expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    typedef struct packed {
        logic        pin;
        logic        wen;
        logic [3:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 4'h0, 32'h3,        4'h0, 32'h3,        1'b0}, // R1 rising mode
        '{1'b1, 1'b1, 4'h8, 32'h1,        4'h8, 32'h1,        1'b0}, // R6 enable on
        '{1'b0, 1'b0, 4'h0, 32'h0,        4'h4, 32'h0,        1'b0}, // R3 wrong direction
        '{1'b1, 1'b0, 4'h0, 32'h0,        4'h4, 32'h1,        1'b1}, // R3 rising edge
        '{1'b1, 1'b1, 4'h4, 32'h0,        4'h4, 32'h1,        1'b1}, // R4 write zero
        '{1'b1, 1'b1, 4'h4, 32'h1,        4'h4, 32'h0,        1'b0}, // R4 write one
        '{1'b1, 1'b1, 4'h0, 32'h2,        4'h4, 32'h1,        1'b1}, // R2 level high
        '{1'b0, 1'b1, 4'h4, 32'h1,        4'h4, 32'h1,        1'b1}, // R4 level still seen
        '{1'b0, 1'b1, 4'h4, 32'h1,        4'h4, 32'h0,        1'b0}, // R4 level gone
        '{1'b0, 1'b1, 4'h0, 32'hABCD0001, 4'h0, 32'hABCD0001, 1'b0}, // R1 readback
        '{1'b1, 1'b1, 4'h8, 32'h0,        4'h8, 32'h0,        1'b0}, // R6 enable off
        '{1'b0, 1'b0, 4'h0, 32'h0,        4'h4, 32'h1,        1'b0}, // R6 latch masked
        '{1'b0, 1'b1, 4'hC, 32'hFFFFFFFF, 4'hC, 32'h0,        1'b0}, // R9 unmapped
        '{1'b0, 1'b0, 4'h0, 32'h0,        4'h8, 32'h0,        1'b0}, // R9 no side effect
        '{1'b0, 1'b1, 4'h8, 32'hFFFFFFFF, 4'h8, 32'h1,        1'b1}, // R9 upper bits zero
        '{1'b0, 1'b1, 4'h4, 32'h1,        4'h4, 32'h0,        1'b0}  // R4 edge clear
    };

    initial begin
        logic [31:0] d;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R7: reset state
        rd(4'h0, d); check("R7 ctrl", d, 32'h0);
        rd(4'h4, d); check("R7 pend", d, 32'h0);
        rd(4'h8, d); check("R7 en", d, 32'h0);
        check("R7 irq", {31'h0, irq_out}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            nmi_pin = VECS[i].pin;
            if (VECS[i].wen) begin
                bus_addr = VECS[i].waddr; bus_wdata = VECS[i].wdata; bus_wr_en = 1'b1;
            end
            @(negedge clk);
            bus_wr_en = 1'b0;
            repeat (4) @(negedge clk);
            rd(VECS[i].raddr, d);
            check($sformatf("vector %0d rdata", i), d, VECS[i].exp);
            check($sformatf("vector %0d irq", i), {31'h0, irq_out}, {31'h0, VECS[i].exp_irq});
        end

        // R10: exact latency, rising mode, enable on, pin low and idle
        wr(4'h0, 32'h3);
        wr(4'h8, 32'h1);
        repeat (4) @(negedge clk);
        nmi_pin = 1'b1;
        bus_addr = 4'h4;
        @(negedge clk); rd(4'h4, d); check("R10 pend after edge1", d, 32'h0);
        @(negedge clk); rd(4'h4, d); check("R10 pend after edge2", d, 32'h0);
        @(negedge clk); rd(4'h4, d); check("R10 pend after edge3", d, 32'h1);
        check("R10 irq after edge3", {31'h0, irq_out}, 32'h0);
        @(negedge clk); check("R10 irq after edge4", {31'h0, irq_out}, 32'h1);
        wr(4'h4, 32'h1);
        @(negedge clk); rd(4'h4, d); check("R4 clear after latency test", d, 32'h0);

        // R5: clearing write lands in the same cycle as a rising-edge event
        nmi_pin = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'h4, d); check("R5 no event on fall", d, 32'h0);
        nmi_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_addr = 4'h4; bus_wdata = 32'h1; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        @(negedge clk);
        rd(4'h4, d); check("R5 set wins over clear", d, 32'h1);

        // R7: reset in mid-run with pending and enable set
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'h0, d); check("R7 ctrl after rerun reset", d, 32'h0);
        rd(4'h4, d); check("R7 pend after rerun reset", d, 32'h0);
        rd(4'h8, d); check("R7 en after rerun reset", d, 32'h0);
        check("R7 irq after rerun reset", {31'h0, irq_out}, 32'h0);

        // R8: swapped layout puts enable at 0x04 and pending at 0x08
        wr(4'h4, 32'h1);
        @(negedge clk);
        bus_addr = 4'h4; #1;
        check("R8 swap enable at 0x04", swp_rdata, 32'h1);
        bus_addr = 4'h8; #1;
        check("R8 swap pending at 0x08", swp_rdata, 32'h0);
        rd(4'h8, d); check("R8 default enable at 0x08", d, 32'h0);
        check("R8 swap irq", {31'h0, swp_irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule